// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions against an external PHY over a two-wire serial interface: a clock line (MDC) that the block drives, and a bidirectional data line (MDIO) whose output enable the block controls. A host presents a request: a read/write flag, a 5-bit PHY address, a register address and 16 bits of write data. The block then clocks out the whole frame. Every frame opens with a preamble of driven ones. A read sends a short 16-bit command and then samples the released line. A write sends a full 32-bit frame and then gives two released idle clocks. A read ends by returning 16 bits of data, and every transaction ends with a one-cycle completion pulse.

The MDC half-period is a whole number of system clock cycles, set by a parameter. With it the 2.5 MHz limit on MDC can be met at any system clock rate. The host register-address input is wider than the five bits a frame carries. A request whose address lies outside 0..31 finishes straight away and never moves the bus.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While reset is asserted and after it is released, `mdc`, `mdio_oe`, `busy` and `done` are all 0.
- R2: Every accepted, in-range transaction begins with exactly 33 MDC clock periods during which `mdio_oe`=1 and `mdio_o`=1.
- R3: A read then drives exactly 16 command bits, MSB first, sampled at MDC rising edges: `1,1,0,1,1,0`, then the PHY address (bit 4 first), then the register address (bit 4 first).
- R4: After its command, a read gives 19 MDC periods with `mdio_oe`=0 and samples `mdio_i` once per period, before the rising edge. `rd_data` returns samples 2 to 17 of those 19 samples (counted from 0), first sample as bit 15. The two leading samples and the final sample are discarded.
- R5: A write drives exactly 32 bits after the preamble, MSB first: `0,1,0,1`, then the PHY address, then the register address, then `1,0`, then the 16 data bits.
- R6: After its 32 bits, a write gives exactly 2 more MDC periods with `mdio_oe`=0. A read has 68 MDC rising edges in total and a write has 67.
- R7: A request whose register address is above 31 raises `done` in the cycle after acceptance. `busy` stays 0 and MDC never toggles. A read answers `rd_data`=16'hFFFF, and a write leaves `rd_data` unchanged.
- R8: MDC is high for exactly `HALF_DIV` system clock cycles, and consecutive MDC rising edges within a frame lie exactly 2*`HALF_DIV` cycles apart.
- R9: `mdio_o` and `mdio_oe` change only while MDC is low. They hold steady for the whole high phase.
- R10: `busy` is 1 from the cycle after an in-range request is accepted until `done`. Requests presented while `busy`=1 are ignored: the running frame is unchanged and no further frame or `done` follows.
- R11: `done` is a single-cycle pulse, and `busy` is 0 in the cycle `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy`=0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_AW | Register address; values above 31 are rejected |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto MDIO |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Value seen on the MDIO line |

## Verification
Reads are tried with PHY and register addresses of all zeros, all ones and mixed values. This separates address bits that are swapped, inverted or placed in the wrong field of the command. The PHY model returns data patterns that include 16'h0000 and values with distinctive low and high bits, while the released line reads as one. Any off-by-one in the choice of which captured samples form the result then shows up as a shifted or wrong word. Writes with data of all ones, all zeros and mixed values separate the turnaround and data fields from the address fields. Out-of-range addresses on both reads and writes, and a request raised in the middle of a frame, separate rejection and request-gating faults from errors in the frame itself.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS    = 33;
    localparam int RD_CMD_BITS = 16;
    localparam int WR_CMD_BITS = 32;
    localparam int RD_TAIL     = 19;
    localparam int WR_TAIL     = 2;
    localparam int CAP_W       = RD_TAIL;
    localparam int FRAME_W     = WR_CMD_BITS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_CMD  = 2'd2,
        ST_TAIL = 2'd3
    } mdio_state_e;

    typedef struct packed {
        logic        write;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_req_t;

    // Command bits left-aligned in a 32-bit word, first bit at the top.
    function automatic logic [FRAME_W-1:0] build_cmd(input mdio_req_t r);
        logic [FRAME_W-1:0] w;
        if (r.write)
            w = {2'b01, 2'b01, r.phy, r.regad, 2'b10, r.wdata};
        else
            w = {2'b11, 2'b01, 2'b10, r.phy, r.regad, 16'h0000};
        return w;
    endfunction

    function automatic logic [5:0] cmd_last(input logic is_read);
        return is_read ? 6'(RD_CMD_BITS - 1) : 6'(WR_CMD_BITS - 1);
    endfunction

    function automatic logic [5:0] tail_last(input logic is_read);
        return is_read ? 6'(RD_TAIL - 1) : 6'(WR_TAIL - 1);
    endfunction

    function automatic logic reg_in_range(input logic [31:0] a);
        return a < 32'd32;
    endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic half_end
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run)
            cnt <= half_end ? '0 : cnt + 1'b1;
    end

    a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/mdio_cmd_shifter.sv
module mdio_cmd_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load)
            sr <= load_val;
        else if (shift)
            sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/mdio_read_capture.sv
module mdio_read_capture #(
    parameter int W  = 19,
    parameter int LO = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        sample,
    input  logic        din,
    output logic [15:0] data
);
    logic [W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cap <= '0;
        else if (sample)
            cap <= {cap[W-2:0], din};
    end

    // Last sample sits at bit 0; keep the 16 bits above the LO lowest.
    assign data = cap[LO+15:LO];

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 40,
    parameter int REG_AW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_phy,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_state_e st;
    logic        phase_hi;
    logic [5:0]  bits_left;
    logic        is_read;
    logic        busy_q, done_q, mdc_q, oe_q;
    logic [15:0] rd_q;

    logic        half_end, tx_msb;
    logic [15:0] cap_data;
    logic        accept, in_range, start_ok, start_bad;
    mdio_req_t   req_s;

    assign accept    = req_valid && !busy_q;
    assign in_range  = reg_in_range(32'(req_reg));
    assign start_ok  = accept && in_range;
    assign start_bad = accept && !in_range;

    always_comb begin
        req_s       = '0;
        req_s.write = req_write;
        req_s.phy   = req_phy;
        req_s.regad = req_reg[4:0];
        req_s.wdata = req_wdata;
    end

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_ok),
        .run      (busy_q),
        .half_end (half_end)
    );

    mdio_cmd_shifter #(.W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .load_val (build_cmd(req_s)),
        .shift    (busy_q && half_end && phase_hi && st == ST_CMD && bits_left != 6'd0),
        .msb      (tx_msb)
    );

    mdio_read_capture #(.W(CAP_W), .LO(1)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_ok),
        .sample (busy_q && half_end && !phase_hi && st == ST_TAIL && is_read),
        .din    (mdio_i),
        .data   (cap_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            phase_hi  <= 1'b0;
            bits_left <= '0;
            is_read   <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            mdc_q     <= 1'b0;
            oe_q      <= 1'b0;
            rd_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_bad) begin
                done_q <= 1'b1;
                if (!req_write)
                    rd_q <= 16'hFFFF;
            end else if (start_ok) begin
                busy_q    <= 1'b1;
                st        <= ST_PRE;
                phase_hi  <= 1'b0;
                bits_left <= 6'(PRE_BITS - 1);
                is_read   <= !req_write;
                mdc_q     <= 1'b0;
                oe_q      <= 1'b1;
            end else if (busy_q && half_end) begin
                if (!phase_hi) begin
                    phase_hi <= 1'b1;
                    mdc_q    <= 1'b1;
                end else begin
                    phase_hi <= 1'b0;
                    mdc_q    <= 1'b0;
                    if (bits_left != 6'd0) begin
                        bits_left <= bits_left - 6'd1;
                    end else begin
                        unique case (st)
                            ST_PRE: begin
                                st        <= ST_CMD;
                                bits_left <= cmd_last(is_read);
                            end
                            ST_CMD: begin
                                st        <= ST_TAIL;
                                bits_left <= tail_last(is_read);
                                oe_q      <= 1'b0;
                            end
                            ST_TAIL: begin
                                st     <= ST_IDLE;
                                busy_q <= 1'b0;
                                done_q <= 1'b1;
                                if (is_read)
                                    rd_q <= cap_data;
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = rd_q;
    assign mdc     = mdc_q;
    assign mdio_oe = oe_q;
    assign mdio_o  = (st == ST_PRE) ? 1'b1 : tx_msb;

    a_r2_preamble_high: assert property (@(posedge clk) disable iff (rst)
        st == ST_PRE |-> (oe_q && mdio_o));

    a_r4_tail_released: assert property (@(posedge clk) disable iff (rst)
        st == ST_TAIL |-> !oe_q);

    a_r7_bad_done: assert property (@(posedge clk) disable iff (rst)
        start_bad |=> (done_q && !busy_q));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !mdc_q);

    a_r9_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mdc_q && $past(mdc_q)) |-> ($stable(mdio_o) && $stable(oe_q)));

    a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (busy_q || done_q));

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;

    localparam int HALF = 3;
    localparam int RAW  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [4:0]      req_phy = '0;
    logic [RAW-1:0]  req_reg = '0;
    logic [15:0]     req_wdata = '0;
    logic            busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0]     rd_data;

    always #2.5 clk = ~clk;

    mdio_mgmt_master #(.HALF_DIV(HALF), .REG_AW(RAW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and line resolution (released line pulls up to 1)
    logic        phy_en = 1'b0, phy_bit = 1'b0, phy_read = 1'b0;
    logic [15:0] phy_resp = '0;
    assign mdio_i = phy_en ? phy_bit : (mdio_oe ? mdio_o : 1'b1);

    int errors = 0, checks = 0;
    int edges = 0, nrel = 0, ndrv = 0, per_err = 0, hi_err = 0, stab_err = 0;
    int ndone = 0, cyc_rise = 0, hi_cnt = 0;
    logic [79:0] drv = '0;
    logic mdc_p = 1'b0, o_p = 1'b0, oe_p = 1'b0;

    always @(negedge clk) begin
        cyc_rise = cyc_rise + 1;
        if (done) ndone = ndone + 1;
        if (mdc) hi_cnt = hi_cnt + 1;
        if (mdc && mdc_p && (mdio_o != o_p || mdio_oe != oe_p)) stab_err = stab_err + 1;
        if (!mdc && mdc_p) begin
            if (hi_cnt != HALF) hi_err = hi_err + 1;
            hi_cnt = 0;
        end
        if (mdc && !mdc_p) begin
            if (edges > 0 && cyc_rise != 2*HALF) per_err = per_err + 1;
            cyc_rise = 0;
            edges = edges + 1;
            if (mdio_oe) begin
                drv  = {drv[78:0], mdio_o};
                ndrv = ndrv + 1;
            end else begin
                nrel = nrel + 1;
            end
            if (phy_read) begin
                int k;
                k = edges - 49;
                if (k == 1) begin phy_en = 1'b1; phy_bit = 1'b0; end
                else if (k >= 2 && k <= 17) begin phy_en = 1'b1; phy_bit = phy_resp[17-k]; end
                else phy_en = 1'b0;
            end else begin
                phy_en = 1'b0;
            end
        end
        mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
    end

    task automatic chk(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        edges = 0; nrel = 0; ndrv = 0; per_err = 0; hi_err = 0; stab_err = 0;
        ndone = 0; cyc_rise = 0; hi_cnt = 0; drv = '0;
    endtask

    task automatic issue(input logic wr, input logic [4:0] phy, input logic [RAW-1:0] ra, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0, "R1 reset outputs", {mdc, mdio_oe, busy, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0, "R1 after release", {mdc, mdio_oe, busy, done}, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] resp, input logic poke);
        logic [15:0] cmd;
        cmd = {2'b11, 2'b01, 2'b10, phy, ra};
        phy_resp = resp; phy_read = 1'b1;
        clear_mon();
        issue(1'b0, phy, RAW'(ra), 16'h0);
        chk(busy == 1 && done == 0, "R10 busy after accept", busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_phy = ~phy; req_reg = 8'h07; req_wdata = 16'hBEEF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_done();
        chk(drv[48:16] == {33{1'b1}}, "R2 read preamble", drv[48:16], {33{1'b1}});
        chk(ndrv == 49 && drv[15:0] == cmd, "R3 read command", drv[15:0], cmd);
        chk(nrel == 19, "R4 released read cycles", nrel, 19);
        chk(rd_data == resp, "R4 read data", rd_data, resp);
        chk(edges == 68, "R6 read edge count", edges, 68);
        chk(per_err == 0 && hi_err == 0, "R8 MDC timing", {per_err, hi_err}, 0);
        chk(stab_err == 0, "R9 data stable while MDC high", stab_err, 0);
        chk(ndone == 1 && busy == 0, "R11 single done", ndone, 1);
        if (poke) begin
            repeat (50) @(negedge clk);
            chk(edges == 68 && ndone == 1 && busy == 0, "R10 request while busy ignored", edges, 68);
        end
        phy_read = 1'b0;
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic [31:0] cmd;
        cmd = {2'b01, 2'b01, phy, ra, 2'b10, wd};
        phy_read = 1'b0;
        clear_mon();
        issue(1'b1, phy, RAW'(ra), wd);
        wait_done();
        chk(drv[64:32] == {33{1'b1}}, "R2 write preamble", drv[64:32], {33{1'b1}});
        chk(ndrv == 65 && drv[31:0] == cmd, "R5 write frame", drv[31:0], cmd);
        chk(nrel == 2 && edges == 67, "R6 write released tail", {nrel, edges}, {32'd2, 32'd67});
        chk(per_err == 0 && hi_err == 0 && stab_err == 0, "R8 R9 write timing", {per_err, hi_err, stab_err}, 0);
        chk(ndone == 1 && busy == 0, "R11 write done", ndone, 1);
    endtask

    task automatic t_bad(input logic wr, input logic [RAW-1:0] ra);
        logic [15:0] prev;
        prev = rd_data;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = 5'd1; req_reg = ra; req_wdata = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1 && busy == 0, "R7 immediate done", {done, busy}, 2'b10);
        chk(rd_data == (wr ? prev : 16'hFFFF), "R7 returned data", rd_data, wr ? prev : 16'hFFFF);
        repeat (40) @(negedge clk);
        chk(edges == 0 && mdio_oe == 0 && ndone == 1, "R7 no bus activity", {edges, ndone}, 1);
    endtask

    initial begin
        t_reset();
        t_read(5'd1, 5'd0, 16'h1234, 1'b0);
        t_read(5'h1F, 5'h1F, 16'hA5C3, 1'b0);
        t_read(5'd0, 5'd2, 16'h0000, 1'b0);
        t_write(5'd5, 5'd4, 16'h01E1);
        t_write(5'h1F, 5'h1F, 16'hFFFF);
        t_write(5'd0, 5'd0, 16'h0000);
        t_bad(1'b0, 8'h20);
        t_bad(1'b1, 8'h7F);
        t_read(5'd3, 5'd1, 16'h5A5B, 1'b1);
        t_bad(1'b1, 8'hFF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule